// File: doc/BRIEF.md
# Memory Error Event Counter Bank

This block sits behind a memory ECC checker and turns its error reports into statistics that software reads back. The checker presents corrected and uncorrected errors on two separate report lanes. Each lane carries a valid strobe, a flag that says whether the location is known, and a channel/slot pair. Per-module counters are kept for every (channel, slot) pair. A coarser set indexes by slot number alone, so the same slot on every channel lands in one counter. There are also controller-wide totals, counts for reports that have no location, and a seconds-since-clear counter driven by an internal clock divider.

Software selects any counter through an index and reads it one cycle later. A clear strobe zeroes every counter, the seconds divider and the panic latch. A panic-on-uncorrected enable turns an uncorrected report into a sticky panic output and leaves the per-module uncorrected statistics untouched. Two log enables gate one-cycle log request pulses, but they never change what is counted.

Top module: `memerr_counter_bank`

## Requirements
- R1: A corrected report with a known in-range location (channel < NCH, slot < NSLOT) adds one to fine counter index `ch*NSLOT+slot`, to coarse counter index `2*NFINE+slot` and to the corrected total at index `2*NFINE+2*NSLOT` (NFINE = NCH*NSLOT; defaults 0..8, 18..20, 24).
- R2: An uncorrected report with a known in-range location, while panic is disabled, adds one to fine index `NFINE+ch*NSLOT+slot`, to coarse index `2*NFINE+NSLOT+slot` and to the uncorrected total at index `2*NFINE+2*NSLOT+1` (defaults 9..17, 21..23, 25).
- R3: Every counter saturates at 2^CW-1 and holds there instead of wrapping.
- R4: A report with the location flag low adds one to its class total and to its class's no-location counter (corrected at `2*NFINE+2*NSLOT+2`, uncorrected at `+3`; defaults 26, 27). A known location with channel >= NCH or slot >= NSLOT adds only to the class total.
- R5: A coarse counter merges all channels: reports at the same slot on different channels add to the same coarse counter.
- R6: When panic_en is high, an uncorrected report sets panic_o from the next cycle. panic_o then stays high until a clear. The fine and coarse uncorrected counters do not change, while the uncorrected total and the no-location counts still count.
- R7: A corrected and an uncorrected report in the same cycle are both counted.
- R8: clr_counters zeroes every counter, the seconds divider and panic_o at the next edge. It takes priority over any increment in the same cycle.
- R9: The seconds counter (index NCNT-1, default 28) increments once every TICK_DIV cycles. The first increment comes TICK_DIV edges after the reset or clear edge.
- R10: log_ce_o and log_ue_o pulse high one cycle after a report of their class arrives while that class's log enable is high. Counting is the same whatever the log enables are.
- R11: rd_data shows, one edge after rd_sel is applied, the value the selected counter held before that edge. An rd_sel of NCNT or more reads 0. After reset every index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_valid | input | 1 | Corrected report strobe |
| ce_loc_known | input | 1 | Corrected report carries a location |
| ce_chan | input | CHW | Corrected report channel |
| ce_slot | input | SLW | Corrected report slot |
| ue_valid | input | 1 | Uncorrected report strobe |
| ue_loc_known | input | 1 | Uncorrected report carries a location |
| ue_chan | input | CHW | Uncorrected report channel |
| ue_slot | input | SLW | Uncorrected report slot |
| panic_en | input | 1 | Panic-on-uncorrected enable |
| log_ce_en | input | 1 | Corrected log request enable |
| log_ue_en | input | 1 | Uncorrected log request enable |
| clr_counters | input | 1 | Clear-all strobe |
| rd_sel | input | SELW | Counter select index |
| rd_data | output | CW | Selected counter value |
| panic_o | output | 1 | Sticky panic indication |
| log_ce_o | output | 1 | Corrected log request pulse |
| log_ue_o | output | 1 | Uncorrected log request pulse |

## Verification
The assertions assume that the report inputs are stable and defined at each rising edge. They also assume that panic_en changes only between edges, so the freeze of uncorrected module statistics can be checked one cycle ahead. The stimulus changes every input only on the falling edge. It uses the 2-bit location fields to reach the out-of-range channel and slot value 3 on purpose. A narrow counter width makes saturation reachable, and a short divider makes the seconds behaviour visible.

// File: rtl/memerr_pkg.sv
`timescale 1ns/1ps
package memerr_pkg;
  // position of a module inside the fine-grained block of one class
  function automatic int fine_index(input int chan, input int slot, input int nslot);
    return chan * nslot + slot;
  endfunction

  // a location is usable only when both coordinates fall inside the array
  function automatic bit loc_in_range(input int chan, input int slot,
                                      input int nch, input int nslot);
    return (chan < nch) && (slot < nslot);
  endfunction
endpackage

// File: rtl/memerr_sat_counter.sv
`timescale 1ns/1ps
module memerr_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] sat_next(input logic [W-1:0] cur, input logic step);
    if (step && !(&cur)) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= sat_next(q, inc);
  end
endmodule

// File: rtl/memerr_tick_gen.sv
`timescale 1ns/1ps
module memerr_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  logic [DW-1:0] div_q;

  assign tick = (int'(div_q) == TICK_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (clr)   div_q <= '0;
    else if (tick)  div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/memerr_event_decode.sv
`timescale 1ns/1ps
module memerr_event_decode #(
  parameter int NCH   = 3,
  parameter int NSLOT = 3,
  parameter int CHW   = 2,
  parameter int SLW   = 2
) (
  input  logic                   valid,
  input  logic                   known,
  input  logic [CHW-1:0]         chan,
  input  logic [SLW-1:0]         slot,
  output logic [NCH*NSLOT-1:0]   fine_hit,
  output logic [NSLOT-1:0]       coarse_hit,
  output logic                   noloc_hit,
  output logic                   total_hit
);
  localparam int NFINE = NCH * NSLOT;
  logic placed;

  assign placed    = valid && known &&
                     memerr_pkg::loc_in_range(int'(chan), int'(slot), NCH, NSLOT);
  assign noloc_hit = valid && !known;
  assign total_hit = valid;

  for (genvar i = 0; i < NFINE; i++) begin : g_fine
    assign fine_hit[i] = placed &&
      (memerr_pkg::fine_index(int'(chan), int'(slot), NSLOT) == i);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_coarse
    assign coarse_hit[s] = placed && (int'(slot) == s);
  end
endmodule

// File: rtl/memerr_counter_bank.sv
`timescale 1ns/1ps
module memerr_counter_bank #(
  parameter int NCH      = 3,
  parameter int NSLOT    = 3,
  parameter int CW       = 32,
  parameter int TICK_DIV = 1000,
  parameter int CHW      = $clog2(NCH),
  parameter int SLW      = $clog2(NSLOT),
  parameter int NCNT     = 2 * NCH * NSLOT + 2 * NSLOT + 5,
  parameter int SELW     = $clog2(NCNT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_valid,
  input  logic            ce_loc_known,
  input  logic [CHW-1:0]  ce_chan,
  input  logic [SLW-1:0]  ce_slot,
  input  logic            ue_valid,
  input  logic            ue_loc_known,
  input  logic [CHW-1:0]  ue_chan,
  input  logic [SLW-1:0]  ue_slot,
  input  logic            panic_en,
  input  logic            log_ce_en,
  input  logic            log_ue_en,
  input  logic            clr_counters,
  input  logic [SELW-1:0] rd_sel,
  output logic [CW-1:0]   rd_data,
  output logic            panic_o,
  output logic            log_ce_o,
  output logic            log_ue_o
);
  localparam int NFINE    = NCH * NSLOT;
  localparam int FUE_BASE = NFINE;
  localparam int CCE_BASE = 2 * NFINE;
  localparam int CUE_BASE = CCE_BASE + NSLOT;
  localparam int TCE_IDX  = CUE_BASE + NSLOT;
  localparam int TUE_IDX  = TCE_IDX + 1;
  localparam int NCE_IDX  = TCE_IDX + 2;
  localparam int NUE_IDX  = TCE_IDX + 3;
  localparam int SEC_IDX  = TCE_IDX + 4;

  // named internal events
  logic [NFINE-1:0] ce_fine_hit, ue_fine_hit;
  logic [NSLOT-1:0] ce_coarse_hit, ue_coarse_hit;
  logic             ce_noloc_hit, ue_noloc_hit;
  logic             ce_total_hit, ue_total_hit;
  logic             sec_tick;
  logic             ue_module_ok;
  logic [NCNT-1:0]  cnt_inc;
  logic [CW-1:0]    cnt_q [NCNT];
  logic [NCNT*CW-1:0] cnt_flat;
  logic [CW-1:0]    rd_next;

  memerr_event_decode #(.NCH(NCH), .NSLOT(NSLOT), .CHW(CHW), .SLW(SLW)) u_ce_dec (
    .valid(ce_valid), .known(ce_loc_known), .chan(ce_chan), .slot(ce_slot),
    .fine_hit(ce_fine_hit), .coarse_hit(ce_coarse_hit),
    .noloc_hit(ce_noloc_hit), .total_hit(ce_total_hit)
  );

  memerr_event_decode #(.NCH(NCH), .NSLOT(NSLOT), .CHW(CHW), .SLW(SLW)) u_ue_dec (
    .valid(ue_valid), .known(ue_loc_known), .chan(ue_chan), .slot(ue_slot),
    .fine_hit(ue_fine_hit), .coarse_hit(ue_coarse_hit),
    .noloc_hit(ue_noloc_hit), .total_hit(ue_total_hit)
  );

  memerr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr_counters), .tick(sec_tick)
  );

  // module-level uncorrected statistics are frozen while panic is armed
  assign ue_module_ok = !panic_en;

  always_comb begin
    cnt_inc = '0;
    for (int i = 0; i < NFINE; i++) begin
      cnt_inc[i]            = ce_fine_hit[i];
      cnt_inc[FUE_BASE + i] = ue_fine_hit[i] && ue_module_ok;
    end
    for (int s = 0; s < NSLOT; s++) begin
      cnt_inc[CCE_BASE + s] = ce_coarse_hit[s];
      cnt_inc[CUE_BASE + s] = ue_coarse_hit[s] && ue_module_ok;
    end
    cnt_inc[TCE_IDX] = ce_total_hit;
    cnt_inc[TUE_IDX] = ue_total_hit;
    cnt_inc[NCE_IDX] = ce_noloc_hit;
    cnt_inc[NUE_IDX] = ue_noloc_hit;
    cnt_inc[SEC_IDX] = sec_tick;
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    memerr_sat_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_counters),
      .inc(cnt_inc[k]), .q(cnt_q[k])
    );
    assign cnt_flat[k*CW +: CW] = cnt_q[k];
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCNT; i++)
      if (int'(rd_sel) == i) rd_next = cnt_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      panic_o  <= 1'b0;
      log_ce_o <= 1'b0;
      log_ue_o <= 1'b0;
    end else begin
      rd_data  <= rd_next;
      log_ce_o <= ce_valid && log_ce_en;
      log_ue_o <= ue_valid && log_ue_en;
      if (clr_counters)              panic_o <= 1'b0;
      else if (ue_valid && panic_en) panic_o <= 1'b1;
    end
  end
endmodule

// File: rtl/memerr_counter_bank_chk.sv
`timescale 1ns/1ps
module memerr_counter_bank_chk #(
  parameter int NFINE = 9,
  parameter int NSLOT = 3,
  parameter int NCNT  = 29,
  parameter int CW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_counters,
  input logic              panic_en,
  input logic              ce_valid,
  input logic              ue_valid,
  input logic              log_ce_en,
  input logic              panic_o,
  input logic              log_ce_o,
  input logic [NFINE-1:0]  ce_fine_hit,
  input logic              sec_tick,
  input logic [NCNT*CW-1:0] cnt_flat
);
  localparam int UEF_LO  = NFINE * CW;
  localparam int UEF_HI  = 2 * NFINE * CW - 1;
  localparam int UEC_LO  = (2 * NFINE + NSLOT) * CW;
  localparam int UEC_HI  = (2 * NFINE + 2 * NSLOT) * CW - 1;
  localparam int TCE_LO  = (2 * NFINE + 2 * NSLOT) * CW;
  localparam int SEC_LO  = (NCNT - 1) * CW;

  // R1: one module at most is hit by a single corrected report
  assert_one_module_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ce_fine_hit));

  // R3: a saturated corrected total stays at its maximum
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_flat[TCE_LO +: CW]) && !clr_counters) |=> (&cnt_flat[TCE_LO +: CW]));

  assert_panic_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_valid && panic_en && !clr_counters) |=> panic_o);

  assert_ue_fine_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (panic_en && !clr_counters) |=> $stable(cnt_flat[UEF_HI:UEF_LO]));

  assert_ue_coarse_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (panic_en && !clr_counters) |=> $stable(cnt_flat[UEC_HI:UEC_LO]));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_counters |=> (cnt_flat == '0 && !panic_o));

  assert_sec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_counters && !sec_tick) |=> $stable(cnt_flat[SEC_LO +: CW]));

  assert_log_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_valid && log_ce_en) |=> log_ce_o);

  assert_log_ce_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_valid |=> !log_ce_o);
endmodule

bind memerr_counter_bank memerr_counter_bank_chk #(
  .NFINE(NFINE), .NSLOT(NSLOT), .NCNT(NCNT), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_counters(clr_counters), .panic_en(panic_en),
  .ce_valid(ce_valid), .ue_valid(ue_valid), .log_ce_en(log_ce_en),
  .panic_o(panic_o), .log_ce_o(log_ce_o), .ce_fine_hit(ce_fine_hit),
  .sec_tick(sec_tick), .cnt_flat(cnt_flat)
);

// File: tb/memerr_counter_bank_test.sv
`timescale 1ns/1ps
module memerr_counter_bank_test;
  localparam int NCH = 3, NSLOT = 3, CW = 4, TD = 5;
  localparam int NCNT = 29, MAXV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_valid = 0, ce_loc_known = 0, ue_valid = 0, ue_loc_known = 0;
  logic [1:0] ce_chan = 0, ce_slot = 0, ue_chan = 0, ue_slot = 0;
  logic panic_en = 0, log_ce_en = 0, log_ue_en = 0, clr_counters = 0;
  logic [4:0] rd_sel = 0;
  logic [CW-1:0] rd_data;
  logic panic_o, log_ce_o, log_ue_o;

  always #2.5 clk = ~clk;

  memerr_counter_bank #(.NCH(NCH), .NSLOT(NSLOT), .CW(CW), .TICK_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n),
    .ce_valid(ce_valid), .ce_loc_known(ce_loc_known), .ce_chan(ce_chan), .ce_slot(ce_slot),
    .ue_valid(ue_valid), .ue_loc_known(ue_loc_known), .ue_chan(ue_chan), .ue_slot(ue_slot),
    .panic_en(panic_en), .log_ce_en(log_ce_en), .log_ue_en(log_ue_en),
    .clr_counters(clr_counters), .rd_sel(rd_sel),
    .rd_data(rd_data), .panic_o(panic_o), .log_ce_o(log_ce_o), .log_ue_o(log_ue_o)
  );

  // behavioural reference
  int m[NCNT];
  int div_m = 0;
  bit pan_m = 0;
  int exp_rd = 0;
  bit exp_lce = 0, exp_lue = 0;
  int vectors = 0, errors = 0;
  bit done = 0;

  function automatic int bump(int v);
    return (v < MAXV) ? v + 1 : v;
  endfunction

  task automatic model_edge();
    int sel = int'(rd_sel);
    exp_rd  = (sel < NCNT) ? m[sel] : 0;
    exp_lce = ce_valid && log_ce_en;
    exp_lue = ue_valid && log_ue_en;
    if (clr_counters) begin
      foreach (m[i]) m[i] = 0;
      div_m = 0; pan_m = 0;
    end else begin
      if (ce_valid) begin
        m[24] = bump(m[24]);
        if (!ce_loc_known) m[26] = bump(m[26]);
        else if (ce_chan < 3 && ce_slot < 3) begin
          m[ce_chan*3 + ce_slot] = bump(m[ce_chan*3 + ce_slot]);
          m[18 + ce_slot] = bump(m[18 + ce_slot]);
        end
      end
      if (ue_valid) begin
        m[25] = bump(m[25]);
        if (panic_en) pan_m = 1;
        if (!ue_loc_known) m[27] = bump(m[27]);
        else if (ue_chan < 3 && ue_slot < 3 && !panic_en) begin
          m[9 + ue_chan*3 + ue_slot] = bump(m[9 + ue_chan*3 + ue_slot]);
          m[21 + ue_slot] = bump(m[21 + ue_slot]);
        end
      end
      if (div_m == TD - 1) begin div_m = 0; m[28] = bump(m[28]); end
      else div_m++;
    end
  endtask

  // inputs are set at the falling edge before calling
  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vectors++;
    if (int'(rd_data) != exp_rd || panic_o != pan_m ||
        log_ce_o != exp_lce || log_ue_o != exp_lue) begin
      errors++;
      $display("FAIL %s sel=%0d rd_data=%0d exp=%0d panic=%0b exp=%0b log_ce=%0b exp=%0b log_ue=%0b exp=%0b",
               req, rd_sel, rd_data, exp_rd, panic_o, pan_m, log_ce_o, exp_lce, log_ue_o, exp_lue);
    end
  endtask

  task automatic idle();
    ce_valid = 0; ue_valid = 0; clr_counters = 0;
  endtask

  task automatic sweep(input string req);
    idle();
    for (int i = 0; i < NCNT; i++) begin
      rd_sel = 5'(i);
      step(req);
    end
  endtask

  task automatic ce(input bit k, input int c, input int s, input string req);
    ce_valid = 1; ce_loc_known = k; ce_chan = 2'(c); ce_slot = 2'(s);
    step(req);
    ce_valid = 0;
  endtask

  task automatic ue(input bit k, input int c, input int s, input string req);
    ue_valid = 1; ue_loc_known = k; ue_chan = 2'(c); ue_slot = 2'(s);
    step(req);
    ue_valid = 0;
  endtask

  initial begin
    foreach (m[i]) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11, R8: everything reads zero after reset
    sweep("R11");
    // R1 with R10: corrected reports at distinct modules, logging on
    log_ce_en = 1; log_ue_en = 1;
    ce(1, 0, 0, "R1"); ce(1, 1, 2, "R1"); ce(1, 2, 1, "R1"); ce(1, 1, 2, "R10");
    sweep("R1");
    // R5: same slot on every channel merges into one coarse counter
    ce(1, 0, 1, "R5"); ce(1, 1, 1, "R5"); ce(1, 2, 1, "R5");
    sweep("R5");
    // R2: uncorrected reports
    ue(1, 2, 2, "R2"); ue(1, 0, 1, "R2"); ue(1, 2, 0, "R2");
    sweep("R2");
    // R7: both classes in one cycle
    ce_valid = 1; ce_loc_known = 1; ce_chan = 1; ce_slot = 0;
    ue_valid = 1; ue_loc_known = 1; ue_chan = 1; ue_slot = 0;
    step("R7");
    sweep("R7");
    // R4: no location, then out-of-range channel and slot
    ce(0, 0, 0, "R4"); ue(0, 2, 2, "R4");
    ce(1, 3, 0, "R4"); ce(1, 0, 3, "R4"); ue(1, 3, 1, "R4"); ue(1, 1, 3, "R4");
    sweep("R4");
    // R10: log enables off, counting unchanged
    log_ce_en = 0; log_ue_en = 0;
    ce(1, 0, 2, "R10"); ue(1, 0, 2, "R10");
    log_ce_en = 1;
    ue(1, 0, 2, "R10");
    sweep("R10");
    // R3: saturation of module (2,2) and its coarse counter
    for (int i = 0; i < 20; i++) ce(1, 2, 2, "R3");
    sweep("R3");
    // R6: panic mode freezes module uncorrected statistics
    panic_en = 1;
    ue(1, 1, 1, "R6"); ue(1, 0, 0, "R6"); ue(0, 0, 0, "R6");
    panic_en = 0;
    for (int i = 0; i < 4; i++) step("R6");
    sweep("R6");
    // R8: clear beats increments in the same cycle
    ce_valid = 1; ce_loc_known = 1; ce_chan = 0; ce_slot = 0;
    ue_valid = 1; ue_loc_known = 1; ue_chan = 0; ue_slot = 0;
    clr_counters = 1;
    step("R8");
    sweep("R8");
    // R9: seconds counting after the clear
    clr_counters = 1; step("R9"); idle();
    rd_sel = 5'd28;
    for (int i = 0; i < 30; i++) step("R9");
    // R11: out-of-range select reads zero
    for (int i = 29; i < 32; i++) begin rd_sel = 5'(i); step("R11"); end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule